// File: doc/BRIEF.md
# BCD Real-Time Clock Register File

This block is a byte-wide register file that holds a battery-backed RAM and a small window of timekeeping registers at the top of its address range. The timekeeping registers show seconds, minutes, hours, day of week, date, month and year as BCD bytes. A one-second tick drives a calendar core that carries through every field, including month lengths and leap years.

Software reaches the file in two ways. The direct port takes a full address with each access. The indexed port is a 4-byte window: the address is loaded as a low byte and a high byte, and then a data byte is read or written. Each indexed data write clears the loaded address back to zero. Every write to a clock register is range-checked, and a rejected value leaves the field as it was. A stop flag freezes the time. Two 16-byte RAM windows can each be locked against both reads and writes.

With the default `DEPTH` of 2048, the RAM covers 0x000 to 0x7F8. The clock registers sit at 0x7F9 (seconds), 0x7FA (minutes), 0x7FB (hours), 0x7FC (day of week), 0x7FD (date), 0x7FE (month) and 0x7FF (year).

Top module: `bcd_rtc_regfile`

## Requirements
- R1: On the indexed port, a write at offset 0 loads the low address byte and a write at offset 1 loads the high address byte. A write at offset 2 changes nothing.
- R2: An indexed write at offset 3 stores its byte at the loaded address and then clears the loaded address to 0x0000.
- R3: An indexed read at offset 3 returns the byte at the loaded address. Reads at offsets 0, 1 and 2 return 0xFF.
- R4: Addresses below DEPTH-7 are RAM. DEPTH-7 up to DEPTH-1 hold, in this order, seconds, minutes, hours, day of week, date, month and year. Any address of DEPTH or above reads 0xFF and ignores writes.
- R5: A seconds write replaces the seconds only when bits 6:0 are valid BCD in the range 00 to 59. Bit 7 is always stored as the stop flag. A seconds read returns the stop flag in bit 7 and the BCD seconds in bits 6:0.
- R6: Minutes take bits 6:0 and must be 00 to 59. Hours take bits 5:0 and must be 00 to 23. Date takes bits 5:0 and must be 01 to 31. Month takes bits 4:0 and must be 01 to 12. Year takes all 8 bits and must be 00 to 99. A nibble above 9 or a value out of range leaves the field unchanged.
- R7: A day-of-week write takes the day from bits 2:0 and keeps bit 6 as a stored flag. All other bits are dropped. A read returns the flag in bit 6 and the day in bits 2:0, with all other bits zero.
- R8: While the stop flag is set, ticks do not change the time. Clearing the flag lets counting resume from the frozen value.
- R9: A tick with the stop flag clear advances the seconds. Each field carries into the next one in BCD: seconds to minutes, minutes to hours, hours to date, date to month, month to year. A day rollover also advances the day of week, which wraps from 7 to 1. The year wraps from 99 to 00.
- R10: April, June, September and November end after 30. February ends after 29 when BASE_YEAR+year is a leap year (divisible by 4, and divisible by 400 if divisible by 100), and after 28 otherwise. Every other month ends after 31.
- R11: When lock bit i is set, RAM addresses 0x20+16i up to 0x2F+16i read 0xFF and ignore writes. Clearing the bit gives back the unchanged contents.
- R12: Synchronous reset sets the time to 00:00:00, day 1, date 01, month 01, year 00, with the stop flag and the day flag clear. It also clears the indexed address.
- R13: If a clock-register write and a tick arrive in the same cycle, the write is applied and that tick is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| lock_i | input | NUM_LOCKS | Per-window RAM lock enables |
| dir_we | input | 1 | Direct port write strobe |
| dir_addr | input | ADDR_W | Direct port address |
| dir_wdata | input | 8 | Direct port write data |
| dir_rdata | output | 8 | Direct port read data (combinational) |
| io_we | input | 1 | Indexed port write strobe |
| io_off | input | 2 | Indexed port register offset |
| io_wdata | input | 8 | Indexed port write data |
| io_rdata | output | 8 | Indexed port read data (combinational) |

## Verification
The bench writes to every clock register and feeds it out-of-range values, bad BCD nibbles and set upper bits. A design that skipped validation, or masked the wrong bits, would read back altered fields. It drives carries across a full year boundary and across the ends of February (leap and non-leap years) and April. A wrong month-length table or a broken carry would give a wrong date or month. It covers the stop flag with an invalid seconds value, the tick that collides with a write, and the self-clearing indexed address. A design that lost the address clear, ignored the lock edges at 0x2F/0x30, or leaked a tick during a write would return the wrong byte or a seconds value that is one too high.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;

    typedef logic [7:0] byte_t;

    localparam int NUM_FIELDS = 7;

    // Clock register order within the top window (decoded by address offset).
    typedef enum logic [2:0] {
        F_SEC  = 3'd0,
        F_MIN  = 3'd1,
        F_HOUR = 3'd2,
        F_DOW  = 3'd3,
        F_DATE = 3'd4,
        F_MON  = 3'd5,
        F_YEAR = 3'd6
    } field_e;

    typedef enum logic [1:0] {
        REG_RAM  = 2'd0,
        REG_CLK  = 2'd1,
        REG_NONE = 2'd2
    } region_e;

    // Indexed port offsets.
    localparam logic [1:0] IDX_LO   = 2'd0;
    localparam logic [1:0] IDX_HI   = 2'd1;
    localparam logic [1:0] IDX_DATA = 2'd3;

    typedef struct packed {
        logic       stop;
        logic       cent;
        byte_t      sec;
        byte_t      min;
        byte_t      hour;
        logic [2:0] dow;
        byte_t      date;
        byte_t      mon;
        byte_t      year;
    } tod_t;

    localparam tod_t TOD_RESET = '{
        stop: 1'b0, cent: 1'b0, sec: 8'h00, min: 8'h00, hour: 8'h00,
        dow: 3'd1, date: 8'h01, mon: 8'h01, year: 8'h00
    };

    function automatic int bcd2bin(input byte_t v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic logic bcd_in_range(input byte_t v, input int lo, input int hi);
        int b;
        if (v[7:4] > 4'd9 || v[3:0] > 4'd9) return 1'b0;
        b = bcd2bin(v);
        return (b >= lo) && (b <= hi);
    endfunction

    function automatic byte_t bcd_inc(input byte_t v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Returns {carry, next}: wraps to 'first' once 'last' is reached or passed.
    function automatic logic [8:0] bcd_step(input byte_t v, input byte_t last, input byte_t first);
        if (v >= last) return {1'b1, first};
        return {1'b0, bcd_inc(v)};
    endfunction

    function automatic logic is_leap(input int full_year);
        if (full_year % 400 == 0) return 1'b1;
        if (full_year % 100 == 0) return 1'b0;
        return (full_year % 4 == 0);
    endfunction

    function automatic byte_t month_last(input byte_t mon, input logic leap);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter int BASE_YEAR = 2000
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   wr_en,
    input  field_e wr_field,
    input  byte_t  wr_data,
    output tod_t   tod
);

    tod_t       tod_q;
    tod_t       nx;
    logic [8:0] s_c, m_c, h_c, d_c, mo_c;
    logic       leap;

    always_comb begin
        nx   = tod_q;
        s_c  = '0;
        m_c  = '0;
        h_c  = '0;
        d_c  = '0;
        mo_c = '0;
        leap = is_leap(BASE_YEAR + bcd2bin(tod_q.year));
        if (wr_en) begin
            // A register write takes the cycle; a coincident tick is dropped.
            unique case (wr_field)
                F_SEC: begin
                    nx.stop = wr_data[7];
                    if (bcd_in_range({1'b0, wr_data[6:0]}, 0, 59)) nx.sec = {1'b0, wr_data[6:0]};
                end
                F_MIN:  if (bcd_in_range({1'b0, wr_data[6:0]}, 0, 59)) nx.min  = {1'b0, wr_data[6:0]};
                F_HOUR: if (bcd_in_range({2'b0, wr_data[5:0]}, 0, 23)) nx.hour = {2'b0, wr_data[5:0]};
                F_DOW: begin
                    nx.dow  = wr_data[2:0];
                    nx.cent = wr_data[6];
                end
                F_DATE: if (bcd_in_range({2'b0, wr_data[5:0]}, 1, 31)) nx.date = {2'b0, wr_data[5:0]};
                F_MON:  if (bcd_in_range({3'b0, wr_data[4:0]}, 1, 12)) nx.mon  = {3'b0, wr_data[4:0]};
                F_YEAR: if (bcd_in_range(wr_data, 0, 99))               nx.year = wr_data;
                default: ;
            endcase
        end else if (tick && !tod_q.stop) begin
            s_c    = bcd_step(tod_q.sec, 8'h59, 8'h00);
            nx.sec = s_c[7:0];
            if (s_c[8]) begin
                m_c    = bcd_step(tod_q.min, 8'h59, 8'h00);
                nx.min = m_c[7:0];
                if (m_c[8]) begin
                    h_c     = bcd_step(tod_q.hour, 8'h23, 8'h00);
                    nx.hour = h_c[7:0];
                    if (h_c[8]) begin
                        nx.dow  = (tod_q.dow >= 3'd7) ? 3'd1 : tod_q.dow + 3'd1;
                        d_c     = bcd_step(tod_q.date, month_last(tod_q.mon, leap), 8'h01);
                        nx.date = d_c[7:0];
                        if (d_c[8]) begin
                            mo_c   = bcd_step(tod_q.mon, 8'h12, 8'h01);
                            nx.mon = mo_c[7:0];
                            if (mo_c[8]) begin
                                nx.year = (tod_q.year >= 8'h99) ? 8'h00 : bcd_inc(tod_q.year);
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tod_q <= TOD_RESET;
        else     tod_q <= nx;
    end

    assign tod = tod_q;

endmodule

// File: rtl/rtc_index_port.sv
`timescale 1ns/1ps
module rtc_index_port
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        off,
    input  byte_t             wdata,
    output logic [ADDR_W-1:0] addr,
    output logic              data_we
);

    localparam int HI_W = ADDR_W - 8;

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (we) begin
            case (off)
                IDX_LO:   addr_q[7:0]        <= wdata;
                IDX_HI:   addr_q[ADDR_W-1:8] <= wdata[HI_W-1:0];
                IDX_DATA: addr_q             <= '0;
                default:  ;
            endcase
        end
    end

    assign addr    = addr_q;
    assign data_we = we && (off == IDX_DATA);

endmodule

// File: rtl/rtc_ram_bank.sv
`timescale 1ns/1ps
module rtc_ram_bank
    import rtc_pkg::*;
#(
    parameter int DEPTH     = 2048,
    parameter int AW        = 11,
    parameter int NRD       = 2,
    parameter int NUM_LOCKS = 2,
    parameter int LOCK_BASE = 32,
    parameter int LOCK_SPAN = 16
) (
    input  logic                    clk,
    input  logic [NUM_LOCKS-1:0]    lock,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  byte_t                   wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][7:0]     rdata
);

    byte_t mem [DEPTH];

    function automatic logic blocked(input logic [AW-1:0] a, input logic [NUM_LOCKS-1:0] lk);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < NUM_LOCKS; i++) begin
            if (lk[i] && int'(a) >= LOCK_BASE + i * LOCK_SPAN &&
                int'(a) < LOCK_BASE + (i + 1) * LOCK_SPAN) begin
                hit = 1'b1;
            end
        end
        return hit;
    endfunction

    always_ff @(posedge clk) begin
        if (we && !blocked(waddr, lock)) mem[waddr] <= wdata;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = blocked(raddr[p], lock) ? 8'hFF : mem[raddr[p]];
    end

endmodule

// File: rtl/bcd_rtc_regfile.sv
`timescale 1ns/1ps
module bcd_rtc_regfile
    import rtc_pkg::*;
#(
    parameter int DEPTH     = 2048,
    parameter int BASE_YEAR = 2000,
    parameter int ADDR_W    = 16,
    parameter int NUM_LOCKS = 2,
    parameter int LOCK_BASE = 32,
    parameter int LOCK_SPAN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic [NUM_LOCKS-1:0] lock_i,
    input  logic              dir_we,
    input  logic [ADDR_W-1:0] dir_addr,
    input  logic [7:0]        dir_wdata,
    output logic [7:0]        dir_rdata,
    input  logic              io_we,
    input  logic [1:0]        io_off,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata
);

    localparam int AW       = $clog2(DEPTH);
    localparam int CLK_BASE = DEPTH - NUM_FIELDS;
    localparam int NRD      = 2;

    function automatic region_e region_of(input logic [ADDR_W-1:0] a);
        if (int'(a) < CLK_BASE) return REG_RAM;
        if (int'(a) < DEPTH)    return REG_CLK;
        return REG_NONE;
    endfunction

    function automatic field_e field_of(input logic [ADDR_W-1:0] a);
        return field_e'(3'(int'(a) - CLK_BASE));
    endfunction

    function automatic byte_t clock_byte(input tod_t t, input field_e f);
        case (f)
            F_SEC:   return t.sec | {t.stop, 7'b0};
            F_MIN:   return t.min;
            F_HOUR:  return t.hour;
            F_DOW:   return {1'b0, t.cent, 3'b0, t.dow};
            F_DATE:  return t.date;
            F_MON:   return t.mon;
            F_YEAR:  return t.year;
            default: return 8'hFF;
        endcase
    endfunction

    // Indexed address register
    logic [ADDR_W-1:0] idx_addr;
    logic              idx_dwe;

    rtc_index_port #(.ADDR_W(ADDR_W)) u_idx (
        .clk     (clk),
        .rst     (rst),
        .we      (io_we),
        .off     (io_off),
        .wdata   (io_wdata),
        .addr    (idx_addr),
        .data_we (idx_dwe)
    );

    // Write arbitration: the direct port wins a same-cycle collision.
    logic              w_en;
    logic [ADDR_W-1:0] w_addr;
    byte_t             w_data;
    logic              ram_we;
    logic              cal_wr;

    always_comb begin
        w_en   = dir_we || idx_dwe;
        w_addr = dir_we ? dir_addr  : idx_addr;
        w_data = dir_we ? dir_wdata : io_wdata;
    end

    assign ram_we = w_en && (region_of(w_addr) == REG_RAM);
    assign cal_wr = w_en && (region_of(w_addr) == REG_CLK);

    // Calendar core
    tod_t tod;

    rtc_calendar #(.BASE_YEAR(BASE_YEAR)) u_cal (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_1hz),
        .wr_en    (cal_wr),
        .wr_field (field_of(w_addr)),
        .wr_data  (w_data),
        .tod      (tod)
    );

    // RAM with lockable windows, one read port per access path
    logic [NRD-1:0][ADDR_W-1:0] rd_addr;
    logic [NRD-1:0][AW-1:0]     ram_raddr;
    logic [NRD-1:0][7:0]        ram_rd;
    logic [NRD-1:0][7:0]        rd_val;

    assign rd_addr[0] = dir_addr;
    assign rd_addr[1] = idx_addr;

    for (genvar p = 0; p < NRD; p++) begin : g_port
        assign ram_raddr[p] = rd_addr[p][AW-1:0];
        assign rd_val[p] = (region_of(rd_addr[p]) == REG_RAM) ? ram_rd[p] :
                           (region_of(rd_addr[p]) == REG_CLK) ? clock_byte(tod, field_of(rd_addr[p])) :
                           8'hFF;
    end

    rtc_ram_bank #(
        .DEPTH     (DEPTH),
        .AW        (AW),
        .NRD       (NRD),
        .NUM_LOCKS (NUM_LOCKS),
        .LOCK_BASE (LOCK_BASE),
        .LOCK_SPAN (LOCK_SPAN)
    ) u_ram (
        .clk   (clk),
        .lock  (lock_i),
        .we    (ram_we),
        .waddr (w_addr[AW-1:0]),
        .wdata (w_data),
        .raddr (ram_raddr),
        .rdata (ram_rd)
    );

    assign dir_rdata = rd_val[0];
    assign io_rdata  = (io_off == IDX_DATA) ? rd_val[1] : 8'hFF;

endmodule

// File: rtl/rtc_regfile_chk.sv
`timescale 1ns/1ps
module rtc_regfile_chk
    import rtc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DEPTH     = 2048,
    parameter int NUM_LOCKS = 2,
    parameter int LOCK_BASE = 32,
    parameter int LOCK_SPAN = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 tick_1hz,
    input logic [NUM_LOCKS-1:0] lock_i,
    input logic [ADDR_W-1:0]    dir_addr,
    input logic [7:0]           dir_rdata,
    input logic                 io_we,
    input logic [1:0]           io_off,
    input logic [7:0]           io_wdata,
    input logic [ADDR_W-1:0]    idx_addr,
    input logic                 cal_wr,
    input tod_t                 tod
);

    p_low_byte_r1: assert property (@(posedge clk) disable iff (rst)
        (io_we && io_off == IDX_LO) |=> (idx_addr[7:0] == $past(io_wdata)));

    p_addr_clear_r2: assert property (@(posedge clk) disable iff (rst)
        (io_we && io_off == IDX_DATA) |=> (idx_addr == '0));

    p_oob_read_r4: assert property (@(posedge clk) disable iff (rst)
        (32'(dir_addr) >= DEPTH) |-> (dir_rdata == 8'hFF));

    p_fields_legal_r6: assert property (@(posedge clk) disable iff (rst)
        bcd_in_range(tod.sec, 0, 59) && bcd_in_range(tod.min, 0, 59) &&
        bcd_in_range(tod.hour, 0, 23) && bcd_in_range(tod.date, 1, 31) &&
        bcd_in_range(tod.mon, 1, 12) && bcd_in_range(tod.year, 0, 99));

    p_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (tod.stop && !cal_wr) |=> $stable(tod));

    p_advance_r9: assert property (@(posedge clk) disable iff (rst)
        (tick_1hz && !tod.stop && !cal_wr) |=> (tod.sec != $past(tod.sec)));

    for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock
        p_locked_read_r11: assert property (@(posedge clk) disable iff (rst)
            (lock_i[i] && 32'(dir_addr) >= LOCK_BASE + i * LOCK_SPAN &&
             32'(dir_addr) < LOCK_BASE + (i + 1) * LOCK_SPAN) |-> (dir_rdata == 8'hFF));
    end

endmodule

bind bcd_rtc_regfile rtc_regfile_chk #(
    .ADDR_W    (ADDR_W),
    .DEPTH     (DEPTH),
    .NUM_LOCKS (NUM_LOCKS),
    .LOCK_BASE (LOCK_BASE),
    .LOCK_SPAN (LOCK_SPAN)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_1hz  (tick_1hz),
    .lock_i    (lock_i),
    .dir_addr  (dir_addr),
    .dir_rdata (dir_rdata),
    .io_we     (io_we),
    .io_off    (io_off),
    .io_wdata  (io_wdata),
    .idx_addr  (idx_addr),
    .cal_wr    (cal_wr),
    .tod       (tod)
);

// File: tb/test_bcd_rtc_regfile.sv
`timescale 1ns/1ps
module test_bcd_rtc_regfile;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_1hz = 1'b0;
    logic [1:0]  lock_i = 2'b00;
    logic        dir_we = 1'b0;
    logic [15:0] dir_addr = 16'h0;
    logic [7:0]  dir_wdata = 8'h0;
    logic [7:0]  dir_rdata;
    logic        io_we = 1'b0;
    logic [1:0]  io_off = 2'd0;
    logic [7:0]  io_wdata = 8'h0;
    logic [7:0]  io_rdata;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    bcd_rtc_regfile i_bcd_rtc_regfile (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .lock_i(lock_i),
        .dir_we(dir_we), .dir_addr(dir_addr), .dir_wdata(dir_wdata), .dir_rdata(dir_rdata),
        .io_we(io_we), .io_off(io_off), .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    localparam logic [15:0] A_SEC = 16'h07F9, A_MIN = 16'h07FA, A_HR = 16'h07FB,
                            A_DOW = 16'h07FC, A_DATE = 16'h07FD, A_MON = 16'h07FE,
                            A_YR = 16'h07FF;

    // {address, write byte, expected read-back, requirement number}
    localparam int NV = 23;
    localparam logic [35:0] VEC [NV] = '{
        {16'h07F9, 8'h45, 8'h45, 4'd5},  // R5 valid seconds
        {16'h07F9, 8'h60, 8'h45, 4'd5},  // R5 60 rejected
        {16'h07F9, 8'h5A, 8'h45, 4'd5},  // R5 bad nibble
        {16'h07FA, 8'h59, 8'h59, 4'd6},  // R6 minutes max
        {16'h07FA, 8'h60, 8'h59, 4'd6},  // R6 minutes over
        {16'h07FB, 8'h23, 8'h23, 4'd6},  // R6 hours max
        {16'h07FB, 8'h24, 8'h23, 4'd6},  // R6 hours over
        {16'h07FB, 8'hC5, 8'h05, 4'd6},  // R6 hours upper bits dropped
        {16'h07FC, 8'h4D, 8'h45, 4'd7},  // R7 flag and day 5
        {16'h07FC, 8'h02, 8'h02, 4'd7},  // R7 flag cleared
        {16'h07FD, 8'h31, 8'h31, 4'd6},  // R6 date max
        {16'h07FD, 8'h00, 8'h31, 4'd6},  // R6 date zero
        {16'h07FD, 8'h32, 8'h31, 4'd6},  // R6 date over
        {16'h07FE, 8'h12, 8'h12, 4'd6},  // R6 month max
        {16'h07FE, 8'h13, 8'h12, 4'd6},  // R6 month over
        {16'h07FE, 8'h00, 8'h12, 4'd6},  // R6 month zero
        {16'h07FE, 8'hE9, 8'h09, 4'd6},  // R6 month upper bits dropped
        {16'h07FF, 8'h99, 8'h99, 4'd6},  // R6 year max
        {16'h07FF, 8'hA0, 8'h99, 4'd6},  // R6 year bad nibble
        {16'h0100, 8'h5A, 8'h5A, 4'd4},  // R4 RAM byte
        {16'h07F8, 8'h33, 8'h33, 4'd4},  // R4 last RAM byte
        {16'h0800, 8'h12, 8'hFF, 4'd4},  // R4 first address past the end
        {16'hFFFF, 8'h00, 8'hFF, 4'd4}   // R4 top of address space
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic dwr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        dir_we = 1'b1; dir_addr = a; dir_wdata = d;
        @(negedge clk);
        dir_we = 1'b0;
    endtask

    task automatic drd(input logic [15:0] a, output logic [7:0] d);
        dir_addr = a;
        #1;
        d = dir_rdata;
    endtask

    task automatic iwr(input logic [1:0] o, input logic [7:0] d);
        @(negedge clk);
        io_we = 1'b1; io_off = o; io_wdata = d;
        @(negedge clk);
        io_we = 1'b0;
    endtask

    task automatic ird(input logic [1:0] o, output logic [7:0] d);
        io_off = o;
        #1;
        d = io_rdata;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick_1hz = 1'b1;
            @(negedge clk);
            tick_1hz = 1'b0;
        end
    endtask

    task automatic set_eod(input logic [7:0] yr, input logic [7:0] mo, input logic [7:0] dt);
        dwr(A_YR, yr); dwr(A_MON, mo); dwr(A_DATE, dt);
        dwr(A_HR, 8'h23); dwr(A_MIN, 8'h59); dwr(A_SEC, 8'h59);
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL R12 watchdog got=timeout exp=finish");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        drd(A_SEC, v);  check("R12 sec", v, 8'h00);
        drd(A_MIN, v);  check("R12 min", v, 8'h00);
        drd(A_HR, v);   check("R12 hour", v, 8'h00);
        drd(A_DOW, v);  check("R12 dow", v, 8'h01);
        drd(A_DATE, v); check("R12 date", v, 8'h01);
        drd(A_MON, v);  check("R12 month", v, 8'h01);
        drd(A_YR, v);   check("R12 year", v, 8'h00);

        // Table of direct writes and read-backs (R4 R5 R6 R7)
        for (int i = 0; i < NV; i++) begin
            dwr(VEC[i][35:20], VEC[i][19:12]);
            drd(VEC[i][35:20], v);
            check($sformatf("R%0d table entry %0d", VEC[i][3:0], i), v, VEC[i][11:4]);
        end

        // R1 R2 indexed write, offset 2 ignored, self-clearing address
        iwr(2'd0, 8'h10); iwr(2'd1, 8'h00); iwr(2'd2, 8'hEE); iwr(2'd3, 8'hA5);
        drd(16'h0010, v); check("R1 indexed write lands at 0x0010", v, 8'hA5);
        iwr(2'd3, 8'h77);
        drd(16'h0000, v); check("R2 address cleared to zero", v, 8'h77);
        drd(16'h0010, v); check("R2 earlier byte untouched", v, 8'hA5);

        // R3 indexed read
        iwr(2'd0, 8'h10); iwr(2'd1, 8'h00);
        ird(2'd3, v); check("R3 indexed data read", v, 8'hA5);
        ird(2'd0, v); check("R3 offset 0 reads FF", v, 8'hFF);
        ird(2'd2, v); check("R3 offset 2 reads FF", v, 8'hFF);

        // R1 R4 indexed access to a clock register via high byte
        iwr(2'd0, 8'hF9); iwr(2'd1, 8'h07); iwr(2'd3, 8'h30);
        drd(A_SEC, v); check("R1 indexed seconds write", v, 8'h30);

        // R11 lock windows
        dwr(16'h0025, 8'h11); dwr(16'h002F, 8'h44); dwr(16'h0030, 8'h55); dwr(16'h0035, 8'h22);
        lock_i = 2'b01;
        drd(16'h0025, v); check("R11 lock0 read 0x25", v, 8'hFF);
        drd(16'h002F, v); check("R11 lock0 read 0x2F", v, 8'hFF);
        drd(16'h0030, v); check("R11 lock0 leaves 0x30", v, 8'h55);
        dwr(16'h0025, 8'h99);
        lock_i = 2'b00;
        drd(16'h0025, v); check("R11 locked write ignored", v, 8'h11);
        lock_i = 2'b10;
        drd(16'h0035, v); check("R11 lock1 read 0x35", v, 8'hFF);
        drd(16'h002F, v); check("R11 lock1 leaves 0x2F", v, 8'h44);
        iwr(2'd0, 8'h35); iwr(2'd1, 8'h00); iwr(2'd3, 8'h66);
        lock_i = 2'b00;
        drd(16'h0035, v); check("R11 locked indexed write ignored", v, 8'h22);

        // R5 R8 stop flag
        dwr(A_SEC, 8'h10); ticks(1);
        drd(A_SEC, v); check("R9 tick advances", v, 8'h11);
        dwr(A_SEC, 8'hE0);
        drd(A_SEC, v); check("R5 stop set with bad seconds", v, 8'h91);
        ticks(3);
        drd(A_SEC, v); check("R8 frozen while stopped", v, 8'h91);
        dwr(A_SEC, 8'h7F);
        drd(A_SEC, v); check("R8 stop cleared", v, 8'h11);
        ticks(1);
        drd(A_SEC, v); check("R8 resumes from frozen value", v, 8'h12);

        // R9 full carry chain and wraps
        set_eod(8'h99, 8'h12, 8'h31); dwr(A_DOW, 8'h47);
        ticks(1);
        drd(A_SEC, v);  check("R9 sec wrap", v, 8'h00);
        drd(A_MIN, v);  check("R9 min wrap", v, 8'h00);
        drd(A_HR, v);   check("R9 hour wrap", v, 8'h00);
        drd(A_DOW, v);  check("R9 dow 7 to 1 keeps flag", v, 8'h41);
        drd(A_DATE, v); check("R9 date wrap", v, 8'h01);
        drd(A_MON, v);  check("R9 month wrap", v, 8'h01);
        drd(A_YR, v);   check("R9 year 99 to 00", v, 8'h00);

        // R10 month lengths
        set_eod(8'h04, 8'h02, 8'h28); ticks(1);
        drd(A_DATE, v); check("R10 leap Feb 29", v, 8'h29);
        set_eod(8'h04, 8'h02, 8'h29); ticks(1);
        drd(A_DATE, v); check("R10 leap Feb end date", v, 8'h01);
        drd(A_MON, v);  check("R10 leap Feb end month", v, 8'h03);
        set_eod(8'h01, 8'h02, 8'h28); ticks(1);
        drd(A_DATE, v); check("R10 plain Feb end date", v, 8'h01);
        drd(A_MON, v);  check("R10 plain Feb end month", v, 8'h03);
        set_eod(8'h01, 8'h04, 8'h30); ticks(1);
        drd(A_DATE, v); check("R10 April end date", v, 8'h01);
        drd(A_MON, v);  check("R10 April end month", v, 8'h05);
        set_eod(8'h01, 8'h05, 8'h30); ticks(1);
        drd(A_DATE, v); check("R10 May 31 exists", v, 8'h31);

        // R13 write and tick in the same cycle
        dwr(A_SEC, 8'h20);
        @(negedge clk);
        dir_we = 1'b1; dir_addr = A_MIN; dir_wdata = 8'h05; tick_1hz = 1'b1;
        @(negedge clk);
        dir_we = 1'b0; tick_1hz = 1'b0;
        drd(A_SEC, v); check("R13 tick dropped", v, 8'h20);
        drd(A_MIN, v); check("R13 write applied", v, 8'h05);
        ticks(1);
        drd(A_SEC, v); check("R13 later tick counts", v, 8'h21);

        // R12 reset mid-run clears stop flag and indexed address
        dwr(A_SEC, 8'hC0); iwr(2'd0, 8'h10);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        drd(A_SEC, v); check("R12 reset clears stop and time", v, 8'h00);
        drd(16'h0000, v);
        begin
            logic [7:0] ram0;
            ram0 = v;
            ird(2'd3, v); check("R12 reset clears indexed address", v, ram0);
        end

        summary();
        $finish;
    end

endmodule